// File: doc/BRIEF.md
# Privatized Line Source-Copy Buffer

This block holds the untouched original value of every cache line that a core has privatized for commutative updating. When a commutative read or write misses in the first-level cache, the line's address and its 64-byte value are written here in the same cycle the cache line fill happens. Later, the merge logic needs three values for each line: memory, updated and source. The source value comes from this buffer, either through an address lookup or through a walk by entry index.

The store is fully associative with a fixed number of entries (eight lines by default, 512 bytes in all). Each fill goes into the lowest-numbered free entry. A fill for an address that is already held is dropped, so the first captured value is kept. A fill that finds no free entry writes nothing, and the requester must merge and release a line first. An entry is released one at a time, after its merge or when its mergeable line is evicted from the cache. A flash-clear input releases every entry in one cycle. Lookups are pipelined with a fixed three-cycle latency.

Top module: `scb_top`

## Requirements
- R1: After reset every entry is invalid, `full_o` is 0 and `lk_vld_o` is 0.
- R2: A fill to an address not held, while a free entry exists, writes address and data into the lowest-numbered free entry. From the next cycle the walk port shows that entry as valid with that address and data.
- R3: A fill whose address matches a valid entry changes nothing, and the entry keeps its first-captured data. The lookup match vector never has more than one bit set.
- R4: `full_o` is 1 exactly when all entries are valid. A fill while full, with no invalidate or clear in that cycle, writes nothing.
- R5: A lookup request sampled at clock edge k gives a result (`lk_vld_o`=1, with hit, index and data) that is visible after edge k+2 and lasts one cycle. The result reflects the contents after edge k.
- R6: A lookup miss returns `lk_hit_o`=0 and all-zero data.
- R7: `inv_i` with index j makes entry j invalid on the next cycle and leaves all other entries unchanged.
- R8: `clear_i` makes every entry invalid in a single cycle.
- R9: An invalidate and a fill in the same cycle resolve with the fill taking priority. If the invalidated entry is the lowest free entry, it ends valid and holds the new address and data.
- R10: A fill in the same cycle as `clear_i` lands in entry 0, and all other entries end invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fill_i | input | 1 | Capture request on a commutative-access miss |
| fill_addr_i | input | ADDR_W | Line address to capture |
| fill_data_i | input | LINE_W | Source value of the line |
| full_o | output | 1 | All entries valid |
| lk_req_i | input | 1 | Lookup request |
| lk_addr_i | input | ADDR_W | Lookup line address |
| lk_vld_o | output | 1 | Lookup result valid (three cycles after request) |
| lk_hit_o | output | 1 | Lookup found the address |
| lk_idx_o | output | $clog2(ENTRIES) | Entry index of the hit |
| lk_data_o | output | LINE_W | Source data on hit, zero on miss |
| walk_idx_i | input | $clog2(ENTRIES) | Entry selected by the merge walk |
| walk_vld_o | output | 1 | Selected entry valid |
| walk_addr_o | output | ADDR_W | Selected entry address |
| walk_data_o | output | LINE_W | Selected entry data |
| inv_i | input | 1 | Release one entry |
| inv_idx_i | input | $clog2(ENTRIES) | Entry to release |
| clear_i | input | 1 | Flash-clear all entries |

## Verification
Captures are tested with new addresses, so that lowest-free placement can be seen after a hole is punched. They are also tested with repeated addresses carrying different data, which shows that the first value is kept rather than overwritten. Further captures are made into a full buffer, alone and together with an invalidate or a flash clear, which separates reject from fill priority. Lookups are tested for both hits and misses, and are sampled one cycle early as well as on time, so a latency off by one cycle shows up.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int unsigned SCB_ENTRIES = 8;
    localparam int unsigned SCB_LINE_W  = 512;
    localparam int unsigned SCB_ADDR_W  = 26;

    // index of the lowest set bit, 0 when none is set
    function automatic int unsigned lowest_set(input logic [63:0] v);
        int unsigned r;
        r = 0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction
endpackage

// File: rtl/scb_alloc.sv
module scb_alloc #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] free_i,
    output logic [N-1:0] sel_o,
    output logic         any_o
);
    always_comb begin
        logic found;
        found = 1'b0;
        sel_o = '0;
        for (int i = 0; i < N; i++) begin
            if (free_i[i] && !found) begin
                sel_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/scb_match.sv
module scb_match #(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 26,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         valid_i,
    input  logic [N-1:0][AW-1:0] addr_i,
    input  logic [AW-1:0]        query_i,
    output logic [N-1:0]         match_o,
    output logic                 hit_o,
    output logic [IW-1:0]        idx_o
);
    import scb_pkg::*;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (addr_i[g] == query_i);
    end

    assign hit_o = |match_o;
    assign idx_o = IW'(lowest_set(64'(match_o)));
endmodule

// File: rtl/scb_top.sv
module scb_top #(
    parameter int unsigned ENTRIES = scb_pkg::SCB_ENTRIES,
    parameter int unsigned ADDR_W  = scb_pkg::SCB_ADDR_W,
    parameter int unsigned LINE_W  = scb_pkg::SCB_LINE_W
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       fill_i,
    input  logic [ADDR_W-1:0]          fill_addr_i,
    input  logic [LINE_W-1:0]          fill_data_i,
    output logic                       full_o,
    input  logic                       lk_req_i,
    input  logic [ADDR_W-1:0]          lk_addr_i,
    output logic                       lk_vld_o,
    output logic                       lk_hit_o,
    output logic [$clog2(ENTRIES)-1:0] lk_idx_o,
    output logic [LINE_W-1:0]          lk_data_o,
    input  logic [$clog2(ENTRIES)-1:0] walk_idx_i,
    output logic                       walk_vld_o,
    output logic [ADDR_W-1:0]          walk_addr_o,
    output logic [LINE_W-1:0]          walk_data_o,
    input  logic                       inv_i,
    input  logic [$clog2(ENTRIES)-1:0] inv_idx_i,
    input  logic                       clear_i
);
    localparam int unsigned IW = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0][LINE_W-1:0] data;
        logic                           s1_req;
        logic [ADDR_W-1:0]              s1_addr;
        logic                           s2_req;
        logic                           s2_hit;
        logic [IW-1:0]                  s2_idx;
        logic                           s3_req;
        logic                           s3_hit;
        logic [IW-1:0]                  s3_idx;
        logic [LINE_W-1:0]              s3_data;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] kill_d;
    logic [ENTRIES-1:0] free_d;
    logic [ENTRIES-1:0] sel_d;
    logic               any_free_d;
    logic [ENTRIES-1:0] dup_vec_d;
    logic               dup_d;
    logic [IW-1:0]      dup_idx_d;
    logic [ENTRIES-1:0] lk_vec_d;
    logic               lk_hit_d;
    logic [IW-1:0]      lk_idx_d;
    logic               do_fill_d;

    // entries released this cycle
    always_comb begin
        kill_d = '0;
        if (clear_i)    kill_d = '1;
        else if (inv_i) kill_d[inv_idx_i] = 1'b1;
    end

    assign free_d = ~st_q.valid | kill_d;

    scb_alloc #(.N(ENTRIES)) u_alloc (
        .free_i (free_d),
        .sel_o  (sel_d),
        .any_o  (any_free_d)
    );

    // duplicate check against entries that survive this cycle
    scb_match #(.N(ENTRIES), .AW(ADDR_W)) u_dup (
        .valid_i (st_q.valid & ~kill_d),
        .addr_i  (st_q.addr),
        .query_i (fill_addr_i),
        .match_o (dup_vec_d),
        .hit_o   (dup_d),
        .idx_o   (dup_idx_d)
    );

    // lookup compare, second pipeline stage
    scb_match #(.N(ENTRIES), .AW(ADDR_W)) u_lk (
        .valid_i (st_q.valid),
        .addr_i  (st_q.addr),
        .query_i (st_q.s1_addr),
        .match_o (lk_vec_d),
        .hit_o   (lk_hit_d),
        .idx_o   (lk_idx_d)
    );

    assign do_fill_d = fill_i && !dup_d && any_free_d;

    always_comb begin
        st_d = st_q;
        st_d.valid = (st_q.valid & ~kill_d) | (do_fill_d ? sel_d : '0);
        for (int e = 0; e < ENTRIES; e++) begin
            if (do_fill_d && sel_d[e]) begin
                st_d.addr[e] = fill_addr_i;
                st_d.data[e] = fill_data_i;
            end
        end
        st_d.s1_req  = lk_req_i;
        st_d.s1_addr = lk_addr_i;
        st_d.s2_req  = st_q.s1_req;
        st_d.s2_hit  = st_q.s1_req && lk_hit_d;
        st_d.s2_idx  = lk_hit_d ? lk_idx_d : '0;
        st_d.s3_req  = st_q.s2_req;
        st_d.s3_hit  = st_q.s2_hit;
        st_d.s3_idx  = st_q.s2_idx;
        st_d.s3_data = st_q.s2_hit ? st_q.data[st_q.s2_idx] : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o      = &st_q.valid;
    assign lk_vld_o    = st_q.s3_req;
    assign lk_hit_o    = st_q.s3_hit;
    assign lk_idx_o    = st_q.s3_idx;
    assign lk_data_o   = st_q.s3_data;
    assign walk_vld_o  = st_q.valid[walk_idx_i];
    assign walk_addr_o = st_q.addr[walk_idx_i];
    assign walk_data_o = st_q.data[walk_idx_i];

    // R2
    fill_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_i && !dup_d && !full_o && !inv_i && !clear_i
        |=> $countones(st_q.valid) == $countones($past(st_q.valid)) + 1);

    // R3
    unique_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lk_vec_d));

    // R4
    full_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_i && full_o && !inv_i && !clear_i
        |=> $stable(st_q.valid) && $stable(st_q.addr));

    // R5
    lk_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_req_i |-> ##3 lk_vld_o);

    // R7
    inv_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inv_i && !fill_i && !clear_i |=> !st_q.valid[$past(inv_idx_i)]);

    // R8
    flash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i && !fill_i |=> st_q.valid == '0);
endmodule

// File: tb/scb_top_tb.sv
`timescale 1ns/100ps
module scb_top_tb;
    localparam int unsigned E  = 8;
    localparam int unsigned AW = 26;
    localparam int unsigned LW = 512;
    localparam int unsigned IW = $clog2(E);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [LW-1:0] fill_data = '0;
    logic          full;
    logic          lk_req = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_vld, lk_hit;
    logic [IW-1:0] lk_idx;
    logic [LW-1:0] lk_data;
    logic [IW-1:0] walk_idx = '0;
    logic          walk_vld;
    logic [AW-1:0] walk_addr;
    logic [LW-1:0] walk_data;
    logic          inv = 1'b0;
    logic [IW-1:0] inv_idx = '0;
    logic          clr = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scb_top #(.ENTRIES(E), .ADDR_W(AW), .LINE_W(LW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .fill_i(fill), .fill_addr_i(fill_addr), .fill_data_i(fill_data),
        .full_o(full),
        .lk_req_i(lk_req), .lk_addr_i(lk_addr),
        .lk_vld_o(lk_vld), .lk_hit_o(lk_hit), .lk_idx_o(lk_idx), .lk_data_o(lk_data),
        .walk_idx_i(walk_idx), .walk_vld_o(walk_vld), .walk_addr_o(walk_addr),
        .walk_data_o(walk_data),
        .inv_i(inv), .inv_idx_i(inv_idx), .clear_i(clr)
    );

    function automatic logic [LW-1:0] mk(input int a, input int salt);
        return {16{32'(a) * 32'h9E37 + 32'(salt)}};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic walk(input int i, input bit ev, input int ea, input int salt,
                        input string tag);
        walk_idx = IW'(i);
        #0.1;
        chk(walk_vld == ev, tag, 64'(walk_vld), 64'(ev));
        if (ev) begin
            chk(walk_addr == AW'(ea), tag, 64'(walk_addr), 64'(ea));
            chk(walk_data == mk(ea, salt), tag, walk_data[63:0], mk(ea, salt) ~^ '0);
        end
    endtask

    task automatic do_fill(input int a, input int salt);
        fill = 1'b1; fill_addr = AW'(a); fill_data = mk(a, salt);
        @(negedge clk);
        fill = 1'b0;
    endtask

    task automatic lookup(input int a, input bit eh, input int ei, input int salt,
                          input string tag);
        lk_req = 1'b1; lk_addr = AW'(a);
        @(negedge clk);
        lk_req = 1'b0;
        @(negedge clk);
        chk(lk_vld == 1'b0, {tag, " early"}, 64'(lk_vld), 64'd0);
        @(negedge clk);
        chk(lk_vld == 1'b1, tag, 64'(lk_vld), 64'd1);
        chk(lk_hit == eh, tag, 64'(lk_hit), 64'(eh));
        if (eh) begin
            chk(lk_idx == IW'(ei), tag, 64'(lk_idx), 64'(ei));
            chk(lk_data == mk(a, salt), tag, lk_data[63:0], mk(a, salt) ~^ '0);
        end else begin
            chk(lk_data == '0, tag, lk_data[63:0], 64'd0);
        end
        @(negedge clk);
        chk(lk_vld == 1'b0, {tag, " pulse"}, 64'(lk_vld), 64'd0);
    endtask

    task automatic t_reset();
        chk(full == 1'b0, "R1 full", 64'(full), 64'd0);
        chk(lk_vld == 1'b0, "R1 lk_vld", 64'(lk_vld), 64'd0);
        for (int i = 0; i < E; i++) walk(i, 1'b0, 0, 0, "R1 entry");
    endtask

    task automatic t_fill_dup();
        do_fill(10, 0);
        walk(0, 1'b1, 10, 0, "R2 first fill");
        do_fill(20, 0);
        walk(1, 1'b1, 20, 0, "R2 second fill");
        do_fill(10, 7);
        walk(0, 1'b1, 10, 0, "R3 dup keeps data");
        walk(2, 1'b0, 0, 0, "R3 dup no alloc");
    endtask

    task automatic t_lookup();
        lookup(20, 1'b1, 1, 0, "R5 hit");
        lookup(99, 1'b0, 0, 0, "R6 miss");
    endtask

    task automatic t_inv_refill();
        inv = 1'b1; inv_idx = 0;
        @(negedge clk);
        inv = 1'b0;
        walk(0, 1'b0, 0, 0, "R7 released");
        walk(1, 1'b1, 20, 0, "R7 neighbour kept");
        do_fill(30, 0);
        walk(0, 1'b1, 30, 0, "R2 lowest free reused");
    endtask

    task automatic t_full();
        for (int i = 2; i < E; i++) do_fill(40 + 10 * i, 0);
        chk(full == 1'b1, "R4 full flag", 64'(full), 64'd1);
        do_fill(200, 0);
        for (int i = 2; i < E; i++) walk(i, 1'b1, 40 + 10 * i, 0, "R4 no overwrite");
        lookup(200, 1'b0, 0, 0, "R4 rejected absent");
    endtask

    task automatic t_inv_fill();
        inv = 1'b1; inv_idx = 3;
        fill = 1'b1; fill_addr = AW'(300); fill_data = mk(300, 3);
        @(negedge clk);
        inv = 1'b0; fill = 1'b0;
        walk(3, 1'b1, 300, 3, "R9 fill wins");
        chk(full == 1'b1, "R9 still full", 64'(full), 64'd1);
    endtask

    task automatic t_flash();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(full == 1'b0, "R8 full cleared", 64'(full), 64'd0);
        for (int i = 0; i < E; i++) walk(i, 1'b0, 0, 0, "R8 all invalid");
    endtask

    task automatic t_flash_fill();
        for (int i = 0; i < 5; i++) do_fill(500 + i, 0);
        clr = 1'b1;
        fill = 1'b1; fill_addr = AW'(400); fill_data = mk(400, 1);
        @(negedge clk);
        clr = 1'b0; fill = 1'b0;
        walk(0, 1'b1, 400, 1, "R10 fill lands");
        for (int i = 1; i < E; i++) walk(i, 1'b0, 0, 0, "R10 rest cleared");
        lookup(400, 1'b1, 0, 1, "R5 hit after clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_dup();
        t_lookup();
        t_inv_refill();
        t_full();
        t_inv_fill();
        t_flash();
        t_flash_fill();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule